// File: doc/BRIEF.md
# Reset Cause Recorder

This block keeps a record of why the chip last went through reset. The reset sources each deliver an event pulse or level: power-on, low-voltage detect, clock loss, PLL lock loss, watchdog, external reset pin, low-leakage wakeup, JTAG, core lockup, software request, debugger request, programming-port reset command and stop-acknowledge error. When one or more of these are high in a clock cycle, the block treats that cycle as a reset event. It rebuilds two status bytes from the sources, with fixed rules for power-on, low-voltage and wakeup resets. It also latches the active-low boot-mode pin into a mode byte. Between events all three bytes hold their values.

Software or a debug agent reads the bytes through a combinational byte read port: status byte A at offset 0, status byte B at offset 1, the mode byte at offset 7. All other offsets read zero. The port is read-only. A low-leakage-mode input selects how pin and wakeup events are reported. While it is high, the chip is in a very-low-leakage state, so a pin event or a wakeup event counts as a wakeup reset. While it is low, the wakeup input has no effect.

Top module: `reset_cause_recorder`

## Requirements
- R1: While rst_n is low at a clock edge, status byte A becomes 0x82 and status byte B becomes 0x00. Mode byte bit 1 becomes 1 if boot_mode_n is low and 0 if it is high.
- R2: An event with src_por high gives byte A = 0x82 and byte B = 0x00, whatever other sources are high.
- R3: An event with src_lvd high and src_por low gives byte A = 0x02 and byte B = 0x00, whatever other sources are high.
- R4: While ll_mode is high, an event with src_pin high (and no power-on or low-voltage) gives byte A = 0x41 and byte B = 0x00.
- R5: While ll_mode is high, an event with src_wake high, src_pin low, and no power-on or low-voltage gives byte A = 0x01 and byte B = 0x00. Byte A bit 0 becomes 1 only on an event in which ll_mode was high.
- R6: While ll_mode is low, src_wake alone is not an event, and all three bytes keep their values.
- R7: Any other event sets the bit of each active source and clears every other status bit, including the wakeup bit. Byte A bits: 2 clock loss, 3 lock loss, 5 watchdog, 6 pin. Byte B bits: 0 JTAG, 1 lockup, 2 software, 3 debugger, 4 programming port, 5 stop-ack error.
- R8: Several sources that are high in the same event cycle all set their bits.
- R9: In cycles with no event, both status bytes hold their values.
- R10: Mode byte bit 1 is reloaded at every reset and every event: it becomes 1 if boot_mode_n is low and 0 if it is high. The other mode bits read 0, and the byte holds between events.
- R11: Reads of any offset other than 0, 1 and 7 return 0x00.
- R12: Byte A bit 4 and byte B bits 7:6 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, treated as a power-on |
| src_por | input | 1 | Power-on detection |
| src_lvd | input | 1 | Low-voltage detection |
| src_loc | input | 1 | External clock lost |
| src_lol | input | 1 | PLL lock lost |
| src_wdog | input | 1 | Watchdog timeout |
| src_pin | input | 1 | External reset pin asserted |
| src_wake | input | 1 | Low-leakage wakeup source fired |
| src_jtag | input | 1 | JTAG-requested reset |
| src_lockup | input | 1 | Core lockup |
| src_sw | input | 1 | Software reset request |
| src_dbg | input | 1 | Debugger reset request |
| src_prog | input | 1 | Programming-port reset command |
| src_sackerr | input | 1 | Stop-acknowledge timeout |
| ll_mode | input | 1 | Chip in very-low-leakage state |
| boot_mode_n | input | 1 | Active-low boot-mode pin |
| rd_addr | input | 3 | Byte read offset |
| rd_data | output | 8 | Byte read data |

## Verification
The bench stacks competing sources on top of power-on and low-voltage events. A design with the priority wrong would leak watchdog or JTAG bits into those fixed patterns. It runs a plain event straight after a wakeup. A recorder that ORs new causes into old ones would leave bit 0 set. It drives src_wake with ll_mode low and then looks for unchanged bytes, to catch a decoder that treats every wakeup as a reset. It also changes the boot pin between events, to expose a mode byte that tracks the pin instead of latching it.

// File: rtl/rcr_pkg.sv
`timescale 1ns/1ps
// rcr_pkg: shared types and bit positions for the reset cause recorder.
// Assumes 8-bit status bytes; positions are fixed by software decode.
package rcr_pkg;
    localparam int BYTE_W = 8;

    // Status byte A positions
    localparam int A_WAKE = 0;
    localparam int A_LVD  = 1;
    localparam int A_LOC  = 2;
    localparam int A_LOL  = 3;
    localparam int A_WDOG = 5;
    localparam int A_PIN  = 6;
    localparam int A_POR  = 7;

    // Status byte B positions
    localparam int B_JTAG = 0;
    localparam int B_LOCK = 1;
    localparam int B_SW   = 2;
    localparam int B_DBG  = 3;
    localparam int B_PROG = 4;
    localparam int B_SACK = 5;

    // One bit per reset source, sampled in a single cycle
    typedef struct packed {
        logic por;
        logic lvd;
        logic loc;
        logic lol;
        logic wdog;
        logic pin;
        logic wake;
        logic jtag;
        logic lockup;
        logic sw;
        logic dbg;
        logic prog;
        logic sackerr;
    } rcr_src_t;
endpackage

// File: rtl/rcr_classify.sv
`timescale 1ns/1ps
// rcr_classify: combinational decode of the source vector into an event
// strobe and the two status bytes to be captured.
// Assumes priority power-on > low-voltage > low-leakage wakeup > plain OR.
module rcr_classify
    import rcr_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  rcr_src_t     src,
    input  logic         ll_mode,
    output logic         event_o,
    output logic [W-1:0] next_a,
    output logic [W-1:0] next_b
);
    logic wake_evt;
    logic plain_any;

    // Event qualification: wakeup only counts in low-leakage mode
    always_comb begin
        wake_evt  = ll_mode & (src.wake | src.pin);
        plain_any = src.loc | src.lol | src.wdog | src.pin | src.jtag |
                    src.lockup | src.sw | src.dbg | src.prog | src.sackerr;
        event_o   = src.por | src.lvd | wake_evt | plain_any;
    end

    // Pattern selection by priority
    always_comb begin
        next_a = '0;
        next_b = '0;
        if (src.por) begin
            next_a[A_POR] = 1'b1;
            next_a[A_LVD] = 1'b1;
        end else if (src.lvd) begin
            next_a[A_LVD] = 1'b1;
        end else if (wake_evt) begin
            next_a[A_WAKE] = 1'b1;
            next_a[A_PIN]  = src.pin;
        end else begin
            next_a[A_LOC]  = src.loc;
            next_a[A_LOL]  = src.lol;
            next_a[A_WDOG] = src.wdog;
            next_a[A_PIN]  = src.pin;
            next_b[B_JTAG] = src.jtag;
            next_b[B_LOCK] = src.lockup;
            next_b[B_SW]   = src.sw;
            next_b[B_DBG]  = src.dbg;
            next_b[B_PROG] = src.prog;
            next_b[B_SACK] = src.sackerr;
        end
    end
endmodule

// File: rtl/rcr_status_regs.sv
`timescale 1ns/1ps
// rcr_status_regs: holds the two status bytes and the mode byte.
// Assumes synchronous active-low reset equals a power-on record.
module rcr_status_regs
    import rcr_pkg::*;
#(
    parameter int W        = BYTE_W,
    parameter int MODE_BIT = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         event_i,
    input  logic [W-1:0] next_a,
    input  logic [W-1:0] next_b,
    input  logic         boot_mode_n,
    output logic [W-1:0] stat_a,
    output logic [W-1:0] stat_b,
    output logic [W-1:0] mode_b
);
    logic [W-1:0] por_pattern;
    logic [W-1:0] mode_next;

    // Constant patterns for reset load and mode capture
    always_comb begin
        por_pattern           = '0;
        por_pattern[A_POR]    = 1'b1;
        por_pattern[A_LVD]    = 1'b1;
        mode_next             = '0;
        mode_next[MODE_BIT]   = ~boot_mode_n;
    end

    // Capture on reset or event, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_a <= por_pattern;
            stat_b <= '0;
            mode_b <= mode_next;
        end else if (event_i) begin
            stat_a <= next_a;
            stat_b <= next_b;
            mode_b <= mode_next;
        end
    end
endmodule

// File: rtl/rcr_read_mux.sv
`timescale 1ns/1ps
// rcr_read_mux: combinational byte read decode; unmapped offsets give zero.
module rcr_read_mux #(
    parameter int W        = 8,
    parameter int AW       = 3,
    parameter int OFF_A    = 0,
    parameter int OFF_B    = 1,
    parameter int OFF_MODE = 7
) (
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  stat_a,
    input  logic [W-1:0]  stat_b,
    input  logic [W-1:0]  mode_b,
    output logic [W-1:0]  data
);
    // Offset decode
    always_comb begin
        if (addr == AW'(OFF_A))         data = stat_a;
        else if (addr == AW'(OFF_B))    data = stat_b;
        else if (addr == AW'(OFF_MODE)) data = mode_b;
        else                            data = '0;
    end
endmodule

// File: rtl/reset_cause_recorder.sv
`timescale 1ns/1ps
// reset_cause_recorder: top level. Records the cause of the latest reset
// event and exposes it on a read-only byte port.
// Assumes source inputs are already synchronous to clk.
module reset_cause_recorder
    import rcr_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int OFF_A    = 0,
    parameter int OFF_B    = 1,
    parameter int OFF_MODE = 7,
    parameter int MODE_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_por,
    input  logic              src_lvd,
    input  logic              src_loc,
    input  logic              src_lol,
    input  logic              src_wdog,
    input  logic              src_pin,
    input  logic              src_wake,
    input  logic              src_jtag,
    input  logic              src_lockup,
    input  logic              src_sw,
    input  logic              src_dbg,
    input  logic              src_prog,
    input  logic              src_sackerr,
    input  logic              ll_mode,
    input  logic              boot_mode_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int W = BYTE_W;

    rcr_src_t     src;
    logic         evt;
    logic [W-1:0] nxt_a, nxt_b;
    logic [W-1:0] stat_a_q, stat_b_q, mode_q;

    // Gather sources into one vector
    always_comb begin
        src = '{por: src_por, lvd: src_lvd, loc: src_loc, lol: src_lol,
                wdog: src_wdog, pin: src_pin, wake: src_wake, jtag: src_jtag,
                lockup: src_lockup, sw: src_sw, dbg: src_dbg, prog: src_prog,
                sackerr: src_sackerr};
    end

    rcr_classify #(.W(W)) u_classify (
        .src     (src),
        .ll_mode (ll_mode),
        .event_o (evt),
        .next_a  (nxt_a),
        .next_b  (nxt_b)
    );

    rcr_status_regs #(.W(W), .MODE_BIT(MODE_BIT)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .event_i     (evt),
        .next_a      (nxt_a),
        .next_b      (nxt_b),
        .boot_mode_n (boot_mode_n),
        .stat_a      (stat_a_q),
        .stat_b      (stat_b_q),
        .mode_b      (mode_q)
    );

    rcr_read_mux #(.W(W), .AW(ADDR_W), .OFF_A(OFF_A), .OFF_B(OFF_B),
                   .OFF_MODE(OFF_MODE)) u_rdmux (
        .addr   (rd_addr),
        .stat_a (stat_a_q),
        .stat_b (stat_b_q),
        .mode_b (mode_q),
        .data   (rd_data)
    );
endmodule

// File: rtl/rcr_checker.sv
`timescale 1ns/1ps
// rcr_checker: temporal properties of the reset cause recorder, bound to top.
module rcr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       src_por,
    input logic       src_lvd,
    input logic       src_loc,
    input logic       src_lol,
    input logic       src_wdog,
    input logic       src_pin,
    input logic       src_wake,
    input logic       src_jtag,
    input logic       src_lockup,
    input logic       src_sw,
    input logic       src_dbg,
    input logic       src_prog,
    input logic       src_sackerr,
    input logic       ll_mode,
    input logic       boot_mode_n,
    input logic [2:0] rd_addr,
    input logic [7:0] rd_data,
    input logic [7:0] stat_a,
    input logic [7:0] stat_b,
    input logic [7:0] mode_b
);
    logic quiet;
    assign quiet = !(src_por | src_lvd | src_loc | src_lol | src_wdog | src_pin |
                     src_jtag | src_lockup | src_sw | src_dbg | src_prog |
                     src_sackerr | (ll_mode & src_wake));

    AST_POR_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        src_por |=> (stat_a == 8'h82 && stat_b == 8'h00)); // R2
    AST_LVD_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        (src_lvd && !src_por) |=> (stat_a == 8'h02 && stat_b == 8'h00)); // R3
    AST_PIN_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (ll_mode && src_pin && !src_por && !src_lvd) |=> (stat_a == 8'h41 && stat_b == 8'h00)); // R4
    AST_WAKE_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_a[0]) |-> $past(ll_mode)); // R5
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> ($stable(stat_a) && $stable(stat_b) && $stable(mode_b))); // R9
    AST_MODE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !quiet |=> (mode_b == {6'b0, !$past(boot_mode_n), 1'b0})); // R10
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr != 3'd0 && rd_addr != 3'd1 && rd_addr != 3'd7) |-> rd_data == 8'h00); // R11
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_a[4] == 1'b0 && stat_b[7:6] == 2'b00)); // R12
endmodule

bind reset_cause_recorder rcr_checker u_rcr_checker (
    .clk(clk), .rst_n(rst_n), .src_por(src_por), .src_lvd(src_lvd),
    .src_loc(src_loc), .src_lol(src_lol), .src_wdog(src_wdog), .src_pin(src_pin),
    .src_wake(src_wake), .src_jtag(src_jtag), .src_lockup(src_lockup),
    .src_sw(src_sw), .src_dbg(src_dbg), .src_prog(src_prog),
    .src_sackerr(src_sackerr), .ll_mode(ll_mode), .boot_mode_n(boot_mode_n),
    .rd_addr(rd_addr), .rd_data(rd_data), .stat_a(stat_a_q), .stat_b(stat_b_q),
    .mode_b(mode_q)
);

// File: tb/reset_cause_recorder_bench.sv
`timescale 1ns/1ps
module reset_cause_recorder_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [12:0] srcs = '0; // {por,lvd,loc,lol,wdog,pin,wake,jtag,lockup,sw,dbg,prog,sack}
    logic ll_mode = 1'b0;
    logic boot_mode_n = 1'b1;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    reset_cause_recorder u_reset_cause_recorder (
        .clk(clk), .rst_n(rst_n),
        .src_por(srcs[12]), .src_lvd(srcs[11]), .src_loc(srcs[10]), .src_lol(srcs[9]),
        .src_wdog(srcs[8]), .src_pin(srcs[7]), .src_wake(srcs[6]), .src_jtag(srcs[5]),
        .src_lockup(srcs[4]), .src_sw(srcs[3]), .src_dbg(srcs[2]), .src_prog(srcs[1]),
        .src_sackerr(srcs[0]), .ll_mode(ll_mode), .boot_mode_n(boot_mode_n),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    typedef struct packed {
        logic [12:0] s;
        logic        ll;
        logic        bootn;
        logic [7:0]  ea;
        logic [7:0]  eb;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{13'h0100, 1'b0, 1'b1, 8'h20, 8'h00}, // R7 watchdog
        '{13'h0600, 1'b0, 1'b0, 8'h0C, 8'h00}, // R8 clock+lock loss
        '{13'h0028, 1'b0, 1'b1, 8'h00, 8'h05}, // R8 jtag+software
        '{13'h0080, 1'b0, 1'b1, 8'h40, 8'h00}, // R7 pin outside low leakage
        '{13'h0017, 1'b0, 1'b0, 8'h00, 8'h3A}, // R8 lockup+dbg+prog+sack
        '{13'h1120, 1'b0, 1'b0, 8'h82, 8'h00}, // R2 por over others
        '{13'h0888, 1'b0, 1'b1, 8'h02, 8'h00}, // R3 lvd over others
        '{13'h0080, 1'b1, 1'b0, 8'h41, 8'h00}, // R4 pin wakeup
        '{13'h0040, 1'b1, 1'b1, 8'h01, 8'h00}, // R5 other wakeup
        '{13'h0160, 1'b1, 1'b0, 8'h01, 8'h00}, // R5 wakeup over wdog/jtag
        '{13'h00C0, 1'b1, 1'b1, 8'h41, 8'h00}, // R4 pin+wake
        '{13'h0100, 1'b0, 1'b1, 8'h20, 8'h00}, // R7 wake bit cleared
        '{13'h0100, 1'b1, 1'b0, 8'h20, 8'h00}  // R7 low leakage, no wake source
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic read_at(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic check_all(input string req, input logic [7:0] ea, input logic [7:0] eb,
                             input logic [7:0] em);
        logic [7:0] d;
        read_at(3'd0, d); check(req, d, ea);
        read_at(3'd1, d); check(req, d, eb);
        read_at(3'd7, d); check(req, d, em);
    endtask

    // One-cycle event: drive at negedge, captured at posedge, read at next negedge
    task automatic pulse(input logic [12:0] s, input logic ll, input logic bn);
        @(negedge clk);
        srcs = s; ll_mode = ll; boot_mode_n = bn;
        @(negedge clk);
        srcs = '0;
    endtask

    initial begin
        #(20 * 100000);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        // R1 reset state with boot pin low
        boot_mode_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1", 8'h82, 8'h00, 8'h02);

        foreach (VECS[i]) begin
            pulse(VECS[i].s, VECS[i].ll, VECS[i].bootn);
            check_all($sformatf("R7/R10 vector %0d", i), VECS[i].ea, VECS[i].eb,
                      VECS[i].bootn ? 8'h00 : 8'h02);
        end

        // R9/R10: idle cycles with boot pin toggled keep everything
        pulse(13'h0100, 1'b0, 1'b1);
        @(negedge clk); boot_mode_n = 1'b0; ll_mode = 1'b1;
        repeat (5) @(negedge clk);
        check_all("R9 hold", 8'h20, 8'h00, 8'h00);

        // R6: wake without low leakage is no event
        pulse(13'h0040, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        check_all("R6 wake ignored", 8'h20, 8'h00, 8'h00);

        // R8/R12: every plain source at once
        pulse(13'h07BF, 1'b0, 1'b1);
        check_all("R8 R12 all plain", 8'h6C, 8'h3F, 8'h00);

        // R11: unmapped offsets
        for (int a = 2; a < 7; a++) begin
            read_at(3'(a), d);
            check("R11 unmapped", d, 8'h00);
        end

        // R1 again: mid-run reset with boot pin high
        @(negedge clk); rst_n = 1'b0; boot_mode_n = 1'b1;
        @(negedge clk); rst_n = 1'b1;
        check_all("R1 rerun", 8'h82, 8'h00, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule